// File: doc/BRIEF.md
# Ring-Checked Translation Buffer with Hardware Refill

This block translates 32-bit virtual addresses to physical addresses through a small set-associative buffer of four ways. Each entry holds a virtual page number, a physical page number, a 4-bit attribute and an 8-bit address-space identifier (ASID). A 32-bit ring register packs four ASIDs, one per byte. The byte position whose value equals an entry's ASID gives that entry's privilege ring. A requester presents an address, an access kind and its current ring. The block answers with a one-cycle `done` pulse that carries the physical address, the entry attribute and a fault cause.

When no entry matches, the block walks the page table by itself. It reads one page-table entry (PTE) through a single-beat memory read port, at an address built from a base register and the shifted virtual address. It writes the fetched entry into the next way in rotation and then repeats the lookup. The refill is not done for privilege-0 accesses that fall inside the page table's own 4 MB window, so the walk cannot recurse.

Top module: `ring_tlb`

## Requirements
- R1: After reset, `done` and `mem_req` are low and `fault` is 0. The ring register holds 0x04030201 (byte 0 = 0x01 … byte 3 = 0x04). Every entry is invalid, so the first access of any page needs a refill.
- R2: An entry's ring is the lowest byte index of the ring register whose byte equals the entry's ASID. A refilled entry takes the ASID found in byte PTE[5:4]. Writing the ring register through `rmap_we`/`rmap_wdata` reassigns the rings of entries already stored.
- R3: An entry takes part in a lookup only if its ASID is nonzero and appears in some byte of the ring register. Otherwise the access is treated as a miss.
- R4: A hit requires the stored page number to equal vaddr[31:12]. The physical address is the entry's 20-bit page number above vaddr[11:0], and `attr` returns PTE[3:0] of the hitting entry.
- R5: If two or more ways hit, the fault is 3 for an instruction fetch and 4 for a data access.
- R6: A miss that is not refilled faults with 1 for a fetch and 2 for a data access. `req_kind` encodes 0 as load, 1 as store and 2 as fetch; 3 counts as data.
- R7: A single hit whose ring is numerically below the requester's ring faults with 5 for a fetch and 6 for a data access. An equal or higher ring gives fault 0.
- R8: The PTE read address is (pt_base OR (vaddr >> 10)) with bits 1:0 cleared.
- R9: The refill is skipped, and a miss fault is reported, when `req_ring` is 0 and vaddr[31:22] equals pt_base[31:22]. At any other ring the same address is refilled.
- R10: The refill way is chosen by pre-incrementing a 2-bit counter that resets to 0, so the first fill goes to way 1. Five pages that share a set evict the first of them and keep the other four.
- R11: A request accepted at clock edge k gives, on a hit or fault without refill, `done` for the one cycle after edge k+1. On a refill, `mem_req` is high for exactly one cycle after edge k+1. The entry is written at the edge that samples `mem_rvalid`, and `done` follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (accepted when idle) |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_ring | input | 2 | Requester's current ring |
| pt_base | input | 32 | Page-table base register |
| rmap_we | input | 1 | Load the ring register |
| rmap_wdata | input | 32 | New ring register value |
| mem_req | output | 1 | PTE read request, one cycle |
| mem_addr | output | 32 | PTE read address |
| mem_rvalid | input | 1 | PTE read data valid |
| mem_rdata | input | 32 | PTE: page [31:12], ring [5:4], attribute [3:0] |
| done | output | 1 | Result valid, one cycle |
| paddr | output | 32 | Physical address (0 on fault) |
| fault | output | 3 | Cause code, 0 when translated |
| attr | output | 4 | Attribute of the hitting entry |

## Verification
The embedded properties check, on every cycle, the one-cycle shape of `mem_req` and `done` and the word alignment of the PTE address. They also check that a multi-way hit, a ring violation, or a miss inside the page-table window at ring 0 ends the lookup with the matching cause and without a memory read. Only the directed scenarios can show the rest. That covers the exact PTE address arithmetic and the ring each reset byte encodes, and the effect of rewriting the ring register on entries already stored. The scenarios also build a duplicate entry that gives a multi-hit, and they show round-robin eviction through which pages still hit after five fills into one set.

// File: rtl/ring_tlb_pkg.sv
package ring_tlb_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_IMISS   = 3'd1,
    CAUSE_DMISS   = 3'd2,
    CAUSE_IMULTI  = 3'd3,
    CAUSE_DMULTI  = 3'd4,
    CAUSE_IPRIV   = 3'd5,
    CAUSE_DPRIV   = 3'd6
  } cause_e;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } walk_state_e;
endpackage

// File: rtl/rtlb_ring_reg.sv
module rtlb_ring_reg #(
  parameter int unsigned RINGS = 4,
  parameter int unsigned ID_W  = 8,
  parameter logic [RINGS*ID_W-1:0] RESET_MAP = 32'h0403_0201
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [RINGS*ID_W-1:0] wr_data,
  output logic [RINGS*ID_W-1:0] map
);
  logic [RINGS*ID_W-1:0] map_q, map_d;

  always_comb begin
    map_d = map_q;
    if (wr_en) map_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= RESET_MAP;
    else        map_q <= map_d;
  end

  assign map = map_q;
endmodule

// File: rtl/rtlb_ring_of.sv
module rtlb_ring_of #(
  parameter int unsigned RINGS = 4,
  parameter int unsigned ID_W  = 8,
  localparam int unsigned RING_W = $clog2(RINGS)
) (
  input  logic [RINGS*ID_W-1:0] map,
  input  logic [ID_W-1:0]       id,
  output logic                  found,
  output logic [RING_W-1:0]     ring
);
  // lowest matching byte index wins
  always_comb begin
    found = 1'b0;
    ring  = '0;
    for (int i = RINGS - 1; i >= 0; i--) begin
      if (map[i*ID_W +: ID_W] == id) begin
        found = 1'b1;
        ring  = RING_W'(i);
      end
    end
  end
endmodule

// File: rtl/rtlb_ways.sv
module rtlb_ways #(
  parameter int unsigned WAYS     = 4,
  parameter int unsigned SET_BITS = 2,
  parameter int unsigned VPN_W    = 20,
  parameter int unsigned PPN_W    = 20,
  parameter int unsigned ATTR_W   = 4,
  parameter int unsigned RINGS    = 4,
  parameter int unsigned ID_W     = 8,
  localparam int unsigned SETS    = 1 << SET_BITS,
  localparam int unsigned WAY_W   = $clog2(WAYS),
  localparam int unsigned RING_W  = $clog2(RINGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RINGS*ID_W-1:0] map,
  input  logic [VPN_W-1:0]      lk_vpn,
  output logic [WAYS-1:0]       hit_vec,
  output logic [RING_W-1:0]     sel_ring,
  output logic [PPN_W-1:0]      sel_ppn,
  output logic [ATTR_W-1:0]     sel_attr,
  input  logic                  fill_we,
  input  logic [WAY_W-1:0]      fill_way,
  input  logic [VPN_W-1:0]      fill_vpn,
  input  logic [PPN_W-1:0]      fill_ppn,
  input  logic [ATTR_W-1:0]     fill_attr,
  input  logic [ID_W-1:0]       fill_id
);
  logic [ID_W-1:0]   id_q   [WAYS][SETS];
  logic [VPN_W-1:0]  vpn_q  [WAYS][SETS];
  logic [PPN_W-1:0]  ppn_q  [WAYS][SETS];
  logic [ATTR_W-1:0] attr_q [WAYS][SETS];

  logic [SET_BITS-1:0] lk_set, fill_set;
  assign lk_set   = lk_vpn[SET_BITS-1:0];
  assign fill_set = fill_vpn[SET_BITS-1:0];

  // identifiers carry the valid state and are the only reset storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++)
          id_q[w][s] <= '0;
    end else if (fill_we) begin
      id_q[fill_way][fill_set] <= fill_id;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      vpn_q[fill_way][fill_set]  <= fill_vpn;
      ppn_q[fill_way][fill_set]  <= fill_ppn;
      attr_q[fill_way][fill_set] <= fill_attr;
    end
  end

  logic [WAYS-1:0][RING_W-1:0] way_ring;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic present;
    rtlb_ring_of #(.RINGS(RINGS), .ID_W(ID_W)) u_ring (
      .map   (map),
      .id    (id_q[w][lk_set]),
      .found (present),
      .ring  (way_ring[w])
    );
    assign hit_vec[w] = (id_q[w][lk_set] != '0) && present &&
                        (vpn_q[w][lk_set] == lk_vpn);
  end

  always_comb begin
    sel_ring = '0;
    sel_ppn  = '0;
    sel_attr = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        sel_ring = way_ring[w];
        sel_ppn  = ppn_q[w][lk_set];
        sel_attr = attr_q[w][lk_set];
      end
    end
  end
endmodule

// File: rtl/ring_tlb.sv
module ring_tlb
  import ring_tlb_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned WAYS      = 4,
  parameter int unsigned SET_BITS  = 2,
  parameter int unsigned ATTR_W    = 4,
  parameter int unsigned ID_W      = 8,
  parameter int unsigned RINGS     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [31:0]         req_vaddr,
  input  logic [1:0]          req_kind,
  input  logic [1:0]          req_ring,
  input  logic [31:0]         pt_base,
  input  logic                rmap_we,
  input  logic [31:0]         rmap_wdata,
  output logic                mem_req,
  output logic [31:0]         mem_addr,
  input  logic                mem_rvalid,
  input  logic [31:0]         mem_rdata,
  output logic                done,
  output logic [31:0]         paddr,
  output logic [2:0]          fault,
  output logic [3:0]          attr
);
  localparam int unsigned VPN_W     = VA_W - PAGE_BITS;
  localparam int unsigned PTE_SHIFT = PAGE_BITS - 2;
  localparam int unsigned DIR_LSB   = PAGE_BITS + PTE_SHIFT;
  localparam int unsigned WAY_W     = $clog2(WAYS);
  localparam int unsigned RING_W    = $clog2(RINGS);
  localparam int unsigned PRING_LSB = ATTR_W;

  // ring register
  logic [RINGS*ID_W-1:0] map;
  rtlb_ring_reg #(.RINGS(RINGS), .ID_W(ID_W)) u_map (
    .clk (clk), .rst_n (rst_n), .wr_en (rmap_we), .wr_data (rmap_wdata), .map (map)
  );

  // captured request
  walk_state_e st_q, st_d;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        kind_q;
  logic [RING_W-1:0] ring_q;
  logic              refilled_q, refilled_d;
  logic [WAY_W-1:0]  rr_q, rr_d;
  logic              cap;

  // entry storage
  logic [WAYS-1:0]   hit_vec;
  logic [RING_W-1:0] sel_ring;
  logic [VPN_W-1:0]  sel_ppn;
  logic [ATTR_W-1:0] sel_attr;
  logic              fill_we;
  logic [WAY_W-1:0]  fill_way;
  logic [ID_W-1:0]   fill_id;
  logic [RING_W-1:0] pte_ring;

  assign pte_ring = mem_rdata[PRING_LSB +: RING_W];
  assign fill_id  = map[pte_ring*ID_W +: ID_W];
  assign fill_way = rr_q + WAY_W'(1);

  rtlb_ways #(
    .WAYS(WAYS), .SET_BITS(SET_BITS), .VPN_W(VPN_W), .PPN_W(VPN_W),
    .ATTR_W(ATTR_W), .RINGS(RINGS), .ID_W(ID_W)
  ) u_ways (
    .clk       (clk),
    .rst_n     (rst_n),
    .map       (map),
    .lk_vpn    (va_q[VA_W-1:PAGE_BITS]),
    .hit_vec   (hit_vec),
    .sel_ring  (sel_ring),
    .sel_ppn   (sel_ppn),
    .sel_attr  (sel_attr),
    .fill_we   (fill_we),
    .fill_way  (fill_way),
    .fill_vpn  (va_q[VA_W-1:PAGE_BITS]),
    .fill_ppn  (mem_rdata[VA_W-1:PAGE_BITS]),
    .fill_attr (mem_rdata[ATTR_W-1:0]),
    .fill_id   (fill_id)
  );

  logic unused_pte_bits;
  assign unused_pte_bits = ^mem_rdata[PAGE_BITS-1:PRING_LSB+RING_W];

  logic any_hit, multi_hit, is_fetch, in_pt_window;
  assign any_hit      = |hit_vec;
  assign multi_hit    = (hit_vec & (hit_vec - WAYS'(1))) != '0;
  assign is_fetch     = (kind_q == KIND_FETCH);
  assign in_pt_window = (ring_q == '0) &&
                        (va_q[VA_W-1:DIR_LSB] == pt_base[VA_W-1:DIR_LSB]);

  // result path
  logic              fin;
  cause_e            fin_cause;
  logic [VA_W-1:0]   fin_pa;
  logic              done_q;
  logic [VA_W-1:0]   pa_q;
  cause_e            cause_q;
  logic [ATTR_W-1:0] attr_q;

  always_comb begin
    st_d       = st_q;
    cap        = 1'b0;
    fin        = 1'b0;
    fin_cause  = CAUSE_NONE;
    fin_pa     = '0;
    fill_we    = 1'b0;
    refilled_d = refilled_q;
    rr_d       = rr_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap        = 1'b1;
          refilled_d = 1'b0;
          st_d       = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (multi_hit) begin
          fin       = 1'b1;
          fin_cause = is_fetch ? CAUSE_IMULTI : CAUSE_DMULTI;
        end else if (any_hit) begin
          fin = 1'b1;
          if (sel_ring < ring_q) fin_cause = is_fetch ? CAUSE_IPRIV : CAUSE_DPRIV;
          else                   fin_pa    = {sel_ppn, va_q[PAGE_BITS-1:0]};
        end else if (in_pt_window || refilled_q) begin
          fin       = 1'b1;
          fin_cause = is_fetch ? CAUSE_IMISS : CAUSE_DMISS;
        end else begin
          st_d = ST_REQ;
        end
        if (fin) st_d = ST_IDLE;
      end
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid) begin
          fill_we    = 1'b1;
          rr_d       = fill_way;
          refilled_d = 1'b1;
          st_d       = ST_LOOK;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      refilled_q <= 1'b0;
      rr_q       <= '0;
      done_q     <= 1'b0;
      cause_q    <= CAUSE_NONE;
      pa_q       <= '0;
      attr_q     <= '0;
      va_q       <= '0;
      kind_q     <= '0;
      ring_q     <= '0;
    end else begin
      st_q       <= st_d;
      refilled_q <= refilled_d;
      rr_q       <= rr_d;
      done_q     <= fin;
      if (cap) begin
        va_q   <= req_vaddr;
        kind_q <= req_kind;
        ring_q <= req_ring;
      end
      if (fin) begin
        cause_q <= fin_cause;
        pa_q    <= fin_pa;
        attr_q  <= sel_attr;
      end
    end
  end

  assign mem_req  = (st_q == ST_REQ);
  assign mem_addr = (pt_base | (va_q >> PTE_SHIFT)) & ~32'h3;
  assign done     = done_q;
  assign paddr    = pa_q;
  assign fault    = cause_q;
  assign attr     = attr_q;

  // properties
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_pte_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  p_multi_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOK && $countones(hit_vec) > 1) |=>
      (done && (fault == CAUSE_IMULTI || fault == CAUSE_DMULTI)));
  p_priv_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOK && $onehot(hit_vec) && sel_ring < ring_q) |=>
      (done && (fault == CAUSE_IPRIV || fault == CAUSE_DPRIV)));
  p_no_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOK && hit_vec == '0 && in_pt_window) |=>
      (done && !mem_req && (fault == CAUSE_IMISS || fault == CAUSE_DMISS)));
endmodule

// File: tb/sim_ring_tlb.sv
module sim_ring_tlb;
  logic        clk, rst_n;
  logic        req_valid, rmap_we, mem_rvalid;
  logic [31:0] req_vaddr, pt_base, rmap_wdata, mem_rdata;
  logic [1:0]  req_kind, req_ring;
  logic        mem_req, done;
  logic [31:0] mem_addr, paddr;
  logic [2:0]  fault;
  logic [3:0]  attr;

  ring_tlb u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_ring(req_ring), .pt_base(pt_base),
    .rmap_we(rmap_we), .rmap_wdata(rmap_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .paddr(paddr), .fault(fault), .attr(attr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int nfetch = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] next_pte = '0;
  int got_n;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(input logic [19:0] ppn, input logic [1:0] rg,
                                         input logic [3:0] at);
    return {ppn, 6'b0, rg, at};
  endfunction

  // page-table memory: answers one negedge after the request
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        nfetch++;
        last_addr = mem_addr;
        @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = next_pte;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic access(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] rg);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_ring = rg;
    @(negedge clk);
    req_valid = 1'b0;
    got_n = 1;
    while (!done && got_n < 40) begin
      @(negedge clk);
      got_n++;
    end
  endtask

  task automatic set_map(input logic [31:0] v);
    @(negedge clk);
    rmap_we = 1'b1; rmap_wdata = v;
    @(negedge clk);
    rmap_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 fault", {29'b0, fault}, 32'd0);
  endtask

  task automatic t_first_fill;
    int f0 = nfetch;
    next_pte = mk_pte(20'hABCDE, 2'd1, 4'h7);
    access(32'h0001_2345, 2'd0, 2'd1);
    chk("R1 fresh entry refills", nfetch, f0 + 1);
    chk("R8 pte address", last_addr, 32'h8000_0048);
    chk("R11 refill latency", got_n, 5);
    chk("R4 paddr after fill", paddr, 32'hABCD_E345);
    chk("R4 attr from pte", {28'b0, attr}, 32'h7);
    chk("R2 reset map ring1 ok", {29'b0, fault}, 32'd0);
  endtask

  task automatic t_hit;
    int f0 = nfetch;
    access(32'h0001_2FF0, 2'd1, 2'd1);
    chk("R11 hit latency", got_n, 2);
    chk("R4 hit paddr", paddr, 32'hABCD_EFF0);
    chk("R4 hit no fetch", nfetch, f0);
    next_pte = mk_pte(20'h33333, 2'd1, 4'h2);
    access(32'h0001_6ABC, 2'd0, 2'd1);
    chk("R4 other page same set refills", nfetch, f0 + 1);
    chk("R4 other page paddr", paddr, 32'h3333_3ABC);
  endtask

  task automatic t_priv;
    int f0 = nfetch;
    access(32'h0001_2000, 2'd0, 2'd2);
    chk("R7 data priv", {29'b0, fault}, 32'd6);
    chk("R7 priv paddr zero", paddr, 32'd0);
    access(32'h0001_2000, 2'd2, 2'd2);
    chk("R7 fetch priv", {29'b0, fault}, 32'd5);
    access(32'h0001_2010, 2'd1, 2'd0);
    chk("R7 lower requester ok", {29'b0, fault}, 32'd0);
    chk("R7 no fetch", nfetch, f0);
  endtask

  task automatic t_skip;
    int f0 = nfetch;
    access(32'h8012_3456, 2'd0, 2'd0);
    chk("R9 skip data miss", {29'b0, fault}, 32'd2);
    chk("R9 skip no fetch", nfetch, f0);
    access(32'h8012_3456, 2'd2, 2'd0);
    chk("R6 fetch miss", {29'b0, fault}, 32'd1);
    chk("R11 miss latency", got_n, 2);
    next_pte = mk_pte(20'h11111, 2'd1, 4'h3);
    access(32'h8012_3456, 2'd0, 2'd1);
    chk("R9 ring1 refills", nfetch, f0 + 1);
    chk("R8 pte address window", last_addr, 32'h8020_048C);
    chk("R9 refilled paddr", paddr, 32'h1111_1456);
  endtask

  task automatic t_ringmap;
    int f0 = nfetch;
    set_map(32'h0102_0304);
    access(32'h0001_2000, 2'd0, 2'd2);
    chk("R2 remapped ring2 ok", {29'b0, fault}, 32'd0);
    access(32'h0001_2000, 2'd0, 2'd3);
    chk("R2 remapped ring3 priv", {29'b0, fault}, 32'd6);
    chk("R2 no fetch", nfetch, f0);
    set_map(32'h0403_0501);
    next_pte = mk_pte(20'h22222, 2'd0, 4'h5);
    access(32'h0001_2004, 2'd0, 2'd0);
    chk("R3 absent asid misses", nfetch, f0 + 1);
    chk("R3 new entry paddr", paddr, 32'h2222_2004);
  endtask

  task automatic t_multi;
    int f0 = nfetch;
    set_map(32'h0403_0201);
    access(32'h0001_2000, 2'd0, 2'd0);
    chk("R5 data multi", {29'b0, fault}, 32'd4);
    access(32'h0001_2000, 2'd2, 2'd0);
    chk("R5 fetch multi", {29'b0, fault}, 32'd3);
    chk("R5 no fetch", nfetch, f0);
  endtask

  task automatic t_rr;
    int f0;
    for (int i = 0; i < 5; i++) begin
      next_pte = mk_pte(20'h40000 + 20'(i), 2'd1, 4'h1);
      access(32'h0010_1000 + 32'(i) * 32'h4000, 2'd0, 2'd1);
    end
    f0 = nfetch;
    for (int i = 1; i < 5; i++) begin
      access(32'h0010_1000 + 32'(i) * 32'h4000, 2'd0, 2'd1);
      chk("R10 kept page hits", paddr, {20'h40000 + 20'(i), 12'h000});
    end
    chk("R10 kept pages no fetch", nfetch, f0);
    next_pte = mk_pte(20'h40000, 2'd1, 4'h1);
    access(32'h0010_1000, 2'd0, 2'd1);
    chk("R10 oldest evicted", nfetch, f0 + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_ring = '0;
    pt_base = 32'h8000_0000; rmap_we = 1'b0; rmap_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_first_fill;
    t_hit;
    t_priv;
    t_skip;
    t_ringmap;
    t_multi;
    t_rr;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule